// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a minimal processor core built around one 16-bit accumulator. Program and data sit in one shared memory, so instruction fetches and operand reads use the same synchronous read port. Every instruction word is 16 bits wide. The top four bits are the opcode and the low twelve bits are a field whose meaning depends on that opcode.

Two opcodes are memory-reference instructions. They read the word at the 12-bit address and add it to the accumulator or subtract it from the accumulator. The all-ones opcode is reserved as an extended group. For that opcode the 12-bit field is a sub-operation code that acts on the accumulator alone, and one sub-code stops the core.

The core sequences fetch, decode and execute by itself. It exposes the accumulator, the program counter and a halted flag so that a surrounding environment can observe its progress.

Top module: `acc_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, the accumulator is 0, the program counter is 0, the halted flag is low, and the core drives a read of address 0.
- R2: Each instruction fetch reads the address held in the program counter. The counter then advances by one, and 4095 is followed by 0.
- R3: Opcode 0x0 adds the memory word at bits 11:0 of the instruction to the accumulator, modulo 2^16.
- R4: Opcode 0x1 subtracts the memory word at bits 11:0 of the instruction from the accumulator, modulo 2^16.
- R5: Opcode 0xF with field 0x000 clears the accumulator, field 0x001 replaces it with its two's-complement negation, field 0x002 inverts every bit, and field 0x003 adds one modulo 2^16.
- R6: The memory port has a one-cycle read latency. A memory-reference instruction takes 4 cycles and makes exactly two reads: the fetch and one operand read at its field address. An opcode-0xF instruction takes 3 cycles and makes only the fetch read.
- R7: Opcodes 0x2 to 0xE, and opcode 0xF with any field other than 0x000 to 0x003 or 0xFFF, leave the accumulator unchanged, make no operand read, and take 3 cycles.
- R8: Opcode 0xF with field 0xFFF raises the halted flag. From then until reset, no read is issued and the accumulator and program counter hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_rd_o | output | 1 | Read request on the shared memory port |
| mem_addr_o | output | 12 | Read address |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the request |
| acc_o | output | 16 | Accumulator value |
| pc_o | output | 12 | Program counter value |
| halted_o | output | 1 | Core has stopped |

## Verification
Instruction fetch and operand read compete for the same memory port, and the two can name the same word. In that case an instruction word is also consumed as data. The bench provokes this with a program whose add operand is a later instruction's own code and whose subtract operand is the subtract instruction itself. It judges the result from the final accumulator value and from the exact sequence of read addresses on the port. A second overlap, the program counter wrapping from 4095 to 0 in the same instruction that halts the core, is provoked by placing the halt at the last address.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_IWAIT,
    ST_DECODE,
    ST_OWAIT,
    ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    AOP_ADD,
    AOP_SUB,
    AOP_CLR,
    AOP_NEG,
    AOP_NOT,
    AOP_INC
  } alu_op_e;

  localparam int unsigned OP_W_DEF   = 4;
  localparam int unsigned ADDR_W_DEF = 12;

  localparam logic [3:0] OPC_ADD = 4'h0;
  localparam logic [3:0] OPC_SUB = 4'h1;
  localparam logic [3:0] OPC_EXT = 4'hF;

  // extended sub-codes, low bits of the field
  localparam int unsigned EXT_CLR = 0;
  localparam int unsigned EXT_NEG = 1;
  localparam int unsigned EXT_NOT = 2;
  localparam int unsigned EXT_INC = 3;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    unique case (op_i)
      AOP_ADD: res_o = acc_i + opnd_i;
      AOP_SUB: res_o = acc_i - opnd_i;
      AOP_CLR: res_o = '0;
      AOP_NEG: res_o = DATA_W'(0) - acc_i;
      AOP_NOT: res_o = ~acc_i;
      AOP_INC: res_o = acc_i + DATA_W'(1);
      default: res_o = acc_i;
    endcase
  end

endmodule

// File: rtl/acc_pc.sv
module acc_pc #(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] pc_o
);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (inc_i) pc_q <= pc_q + ADDR_W'(1);
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int unsigned OP_W   = 4,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned DATA_W = OP_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fetch_o,
  output logic              rd_o,
  output logic              opnd_sel_o,
  output logic [ADDR_W-1:0] field_o,
  output logic              acc_we_o,
  output alu_op_e           alu_op_o,
  output logic              halted_o
);

  state_e            state_q;
  logic [DATA_W-1:0] ir_q;
  logic [OP_W-1:0]   op;
  logic [ADDR_W-1:0] field;
  logic              is_mem, is_ext, is_halt, ext_known;

  assign op    = ir_q[DATA_W-1:ADDR_W];
  assign field = ir_q[ADDR_W-1:0];

  assign is_mem    = (op == OP_W'(OPC_ADD)) || (op == OP_W'(OPC_SUB));
  assign is_ext    = (op == OP_W'(OPC_EXT));
  assign is_halt   = is_ext && (field == {ADDR_W{1'b1}});
  assign ext_known = is_ext && (field <= ADDR_W'(EXT_INC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      ir_q    <= '0;
    end else begin
      unique case (state_q)
        ST_FETCH: state_q <= ST_IWAIT;
        ST_IWAIT: begin
          ir_q    <= rdata_i;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          if (is_mem)       state_q <= ST_OWAIT;
          else if (is_halt) state_q <= ST_HALT;
          else              state_q <= ST_FETCH;
        end
        ST_OWAIT: state_q <= ST_FETCH;
        default:  state_q <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    alu_op_o = AOP_ADD;
    if (state_q == ST_OWAIT) begin
      alu_op_o = (op == OP_W'(OPC_SUB)) ? AOP_SUB : AOP_ADD;
    end else begin
      unique case (field)
        ADDR_W'(EXT_CLR): alu_op_o = AOP_CLR;
        ADDR_W'(EXT_NEG): alu_op_o = AOP_NEG;
        ADDR_W'(EXT_NOT): alu_op_o = AOP_NOT;
        ADDR_W'(EXT_INC): alu_op_o = AOP_INC;
        default:          alu_op_o = AOP_ADD;
      endcase
    end
  end

  assign fetch_o    = (state_q == ST_FETCH);
  assign opnd_sel_o = (state_q == ST_DECODE);
  assign rd_o       = fetch_o || (opnd_sel_o && is_mem);
  assign acc_we_o   = (state_q == ST_OWAIT) || (opnd_sel_o && ext_known);
  assign field_o    = field;
  assign halted_o   = (state_q == ST_HALT);

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int unsigned OP_W   = OP_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  localparam int unsigned DATA_W = OP_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              halted_o
);

  logic              fetch_w, opnd_sel_w, acc_we_w;
  logic [ADDR_W-1:0] field_w, pc_w;
  logic [DATA_W-1:0] acc_q, alu_res_w;
  alu_op_e           alu_op_w;

  acc_ctrl #(.OP_W(OP_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rdata_i    (mem_rdata_i),
    .fetch_o    (fetch_w),
    .rd_o       (mem_rd_o),
    .opnd_sel_o (opnd_sel_w),
    .field_o    (field_w),
    .acc_we_o   (acc_we_w),
    .alu_op_o   (alu_op_w),
    .halted_o   (halted_o)
  );

  acc_pc #(.ADDR_W(ADDR_W)) i_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (fetch_w),
    .pc_o   (pc_w)
  );

  acc_alu #(.DATA_W(DATA_W)) i_alu (
    .acc_i  (acc_q),
    .opnd_i (mem_rdata_i),
    .op_i   (alu_op_w),
    .res_o  (alu_res_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (acc_we_w) acc_q <= alu_res_w;
  end

  assign mem_addr_o = opnd_sel_w ? field_w : pc_w;
  assign acc_o      = acc_q;
  assign pc_o       = pc_w;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fetch_i,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              halted_o
);

  // R2
  fetch_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |-> (mem_rd_o && mem_addr_o == pc_o));

  // R2
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |=> (pc_o == ADDR_W'($past(pc_o) + 1'b1)));

  // R6
  read_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |=> !mem_rd_o);

  // R8
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o) && $stable(acc_o)));

  // R8
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_rd_o);

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_acc_core_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fetch_i    (fetch_w),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .acc_o      (acc_o),
  .pc_o       (pc_o),
  .halted_o   (halted_o)
);

// File: tb/test_acc_core.sv
`timescale 1ns/1ps
module test_acc_core;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mem_rd_o;
  logic [11:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic [15:0] acc_o;
  logic [11:0] pc_o;
  logic        halted_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] mem_q [int];
  logic [11:0] raddr [8];

  always #2 clk = ~clk;

  acc_core i_acc_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .acc_o       (acc_o),
    .pc_o        (pc_o),
    .halted_o    (halted_o)
  );

  // unwritten words read as opcode 0x2 (no-operation)
  function automatic logic [15:0] mem_word(input logic [11:0] a);
    return mem_q.exists(int'(a)) ? mem_q[int'(a)] : 16'h2000;
  endfunction

  always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem_word(mem_addr_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    mem_q.delete();
  endtask

  task automatic run_prog(input int limit, output int cyc, output int nrd);
    @(negedge clk);
    rst_ni = 1'b1;
    cyc = 0;
    nrd = 0;
    while (!halted_o && cyc < limit) begin
      if (mem_rd_o) begin
        if (nrd < 8) raddr[nrd] = mem_addr_o;
        nrd++;
      end
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int cyc, nrd;
    @(negedge clk);
    chk(acc_o == 0 && pc_o == 0 && !halted_o, "R1 reset state", {acc_o, 4'h0, pc_o}, 0);
    chk(mem_rd_o && mem_addr_o == 0, "R1 first read", {mem_rd_o, mem_addr_o}, {1'b1, 12'h0});
    mem_q[0] = 16'h0040; mem_q[1] = 16'hFFFF; mem_q[16'h40] = 16'h1111;
    run_prog(100, cyc, nrd);
    chk(acc_o == 16'h1111 && pc_o == 2, "R1 run before reset", {acc_o, 4'h0, pc_o}, {16'h1111, 16'h2});
    enter_reset();
    #1;
    chk(acc_o == 0 && pc_o == 0 && !halted_o, "R1 reset after run", {acc_o, 3'h0, halted_o, pc_o}, 0);
  endtask

  task automatic t_addsub();
    int cyc, nrd;
    enter_reset();
    mem_q[0] = 16'h0100; mem_q[1] = 16'h0101; mem_q[2] = 16'h1102; mem_q[3] = 16'hFFFF;
    mem_q[16'h100] = 16'h1234; mem_q[16'h101] = 16'hF000; mem_q[16'h102] = 16'h0300;
    run_prog(200, cyc, nrd);
    // R3 wrap: 0x1234+0xF000=0x0234 ; R4 wrap: 0x0234-0x0300=0xFF34
    chk(acc_o == 16'hFF34, "R3 R4 add/sub wrap", acc_o, 16'hFF34);
    chk(nrd == 7, "R6 read count add/sub", nrd, 7);
    chk(raddr[1] == 12'h100 && raddr[5] == 12'h102, "R6 operand addresses",
        {raddr[1], raddr[5]}, {12'h100, 12'h102});
  endtask

  task automatic t_unary();
    logic [15:0] seed [6] = '{16'h00F0, 16'h00F0, 16'h00F0, 16'h00F0, 16'hFFFF, 16'h8000};
    logic [11:0] sub  [6] = '{12'h000, 12'h001, 12'h002, 12'h003, 12'h003, 12'h001};
    logic [15:0] expv [6] = '{16'h0000, 16'hFF10, 16'hFF0F, 16'h00F1, 16'h0000, 16'h8000};
    for (int i = 0; i < 6; i++) begin
      int cyc, nrd;
      enter_reset();
      mem_q[0] = 16'h0080; mem_q[1] = {4'hF, sub[i]}; mem_q[2] = 16'hFFFF;
      mem_q[16'h80] = seed[i];
      run_prog(100, cyc, nrd);
      chk(acc_o == expv[i], $sformatf("R5 sub-code %0h on %0h", sub[i], seed[i]), acc_o, expv[i]);
    end
  endtask

  task automatic t_timing();
    int cyc, nrd;
    enter_reset();
    mem_q[0] = 16'h0010; mem_q[1] = 16'hFFFF; mem_q[16'h10] = 16'h0005;
    run_prog(100, cyc, nrd);
    chk(cyc == 7, "R6 add+halt cycles", cyc, 7);
    chk(nrd == 3, "R6 add+halt reads", nrd, 3);
    enter_reset();
    mem_q[0] = 16'hF003; mem_q[1] = 16'hFFFF;
    run_prog(100, cyc, nrd);
    chk(cyc == 6 && nrd == 2, "R6 ext+halt cycles/reads", {cyc[15:0], nrd[15:0]}, {16'd6, 16'd2});
  endtask

  task automatic t_shared();
    int cyc, nrd;
    enter_reset();
    mem_q[0] = 16'h0003; mem_q[1] = 16'h1001; mem_q[2] = 16'hFFFF; mem_q[3] = 16'h0777;
    run_prog(100, cyc, nrd);
    // 0x0777 - 0x1001 = 0xF776
    chk(acc_o == 16'hF776, "R4 instruction word as operand", acc_o, 16'hF776);
    chk(raddr[0] == 0 && raddr[1] == 3 && raddr[2] == 1 && raddr[3] == 1 && raddr[4] == 2,
        "R2 R6 shared port read order", {raddr[1], raddr[3]}, {12'h3, 12'h1});
  endtask

  task automatic t_nop_wrap_halt();
    int cyc, nrd;
    logic [11:0] pc_h;
    logic [15:0] acc_h;
    enter_reset();
    mem_q[0] = 16'hF003;
    for (int k = 1; k <= 13; k++) mem_q[k] = {k[3:0] + 4'h1, 12'h055};
    mem_q[14] = 16'hF004; mem_q[15] = 16'hF7FF; mem_q[16'hFFF] = 16'hFFFF;
    run_prog(20000, cyc, nrd);
    chk(acc_o == 16'h0001, "R7 no-ops keep accumulator", acc_o, 16'h0001);
    chk(nrd == 4096, "R7 no operand reads", nrd, 4096);
    chk(cyc == 12288, "R7 three cycles each", cyc, 12288);
    chk(pc_o == 0, "R2 counter wraps to 0", pc_o, 0);
    chk(halted_o, "R8 halted flag", halted_o, 1);
    pc_h = pc_o; acc_h = acc_o;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(halted_o && !mem_rd_o && pc_o == pc_h && acc_o == acc_h, "R8 frozen after halt",
          {halted_o, mem_rd_o, pc_o}, {1'b1, 1'b0, pc_h});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R2: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_addsub();
    t_unary();
    t_timing();
    t_shared();
    t_nop_wrap_halt();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule